// File: doc/BRIEF.md
# Triggered Clock Divider with Parent Select

This unit derives a slower tick stream from one of several parent clocks. The parents are modelled as per-cycle enables in a single clock domain. The unit has three parts in series:

- a selector that picks one parent enable;
- an integer pre-divider;
- a main divider whose divisor may carry fractional bits. The main divider works as a phase accumulator.

Software never changes the running divider or selector directly. It writes new field values into shadow registers. It then writes a 1 to a commit bit.

There are two commit bits:

- The main commit bit moves the main divisor into the active register.
- The pre-commit bit moves the selector code and the pre-divisor.

Each copy happens at a period boundary of the stage that it feeds. Each commit bit reads 1 from the commit write until two cycles after the copy, so software can poll for completion. Commit writes are dropped while the clock gate input is low.

A selector code that names no parent stops the output and raises a sticky error flag.

Top module: `clkdiv_sel`

## Requirements
- R1: After reset, `tick_o`, `trig_busy`, `pretrig_busy` and `sel_err` are 0. Reset selects parent 0 with a pre-divisor of 1 and a main divisor of 1.
- R2: The main divisor field occupies bits [DIV_SHIFT+DIV_W-1:DIV_SHIFT] of register 0 (defaults: bits [11:4]). Its stored value is the divisor minus one. The low FRAC_W bits (default 2) are fraction bits, and the +1 applies above them. For example, field 8 means divide by 3 and field 6 means divide by 2.5. With an integer divisor K, `tick_o` pulses once every K ticks of the pre-divider output.
- R3: With a fractional divisor, every interval between output pulses is the floor or the ceiling of the divisor. Over any whole number of fractional periods, the pulse count is exact; for example, divide by 2.5 gives 40 pulses in 100 input ticks.
- R4: Writes to register 0 or register 1 change only the shadow values. The output rate and the selected parent stay the same until a commit.
- R5: Register 2 bit 0 is the main commit and copies only the main divisor. Register 2 bit 1 is the pre-commit and copies only the selector and the pre-divisor. Neither commit touches the other's shadow.
- R6: A commit bit reads 1 from the cycle after its write. The copy takes place at the next output boundary of the stage it feeds, or at once if no parent is selected. The bit returns to 0 two cycles after the copy. With divide by 1 and a parent that ticks every cycle, `trig_busy` reads 1 for exactly three cycles.
- R7: While `gate_en` is 0, `tick_o` stays 0 and commit writes are ignored. The commit bits stay 0, and the earlier divisor is still in use once the gate reopens.
- R8: The selector field occupies bits [2:0] of register 1 and picks bit `par_en[code]`. The pre-divisor field occupies bits [11:8] of register 1 and stores the divisor minus one. The overall output period is the parent period times the pre-divisor times the main divisor.
- R9: A committed selector code of N_PAR or more makes `tick_o` stay 0 and sets `sel_err`. `sel_err` stays set until reset, even after a valid code is committed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gate_en | input | 1 | Clock gate enable; low blocks output and commits |
| par_en | input | N_PAR | Per-cycle tick enables of the parent clocks |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address: 0 main divisor, 1 selector and pre-divisor, 2 commit bits |
| cfg_wdata | input | 32 | Register write data |
| trig_busy | output | 1 | Main commit bit read value |
| pretrig_busy | output | 1 | Pre-commit bit read value |
| tick_o | output | 1 | Divided output, one pulse per output period |
| sel_err | output | 1 | Sticky flag: an undefined parent code was committed |

## Verification
The divider runs with the following divisors and parent patterns:

- divide by 1 and divide by 3 with a parent that ticks every cycle, so the integer field encoding shows directly in the pulse count;
- divide by 2.5, where the pulse intervals separate a true phase accumulator from integer rounding;
- a parent that ticks every other cycle, whose count differs from parent 0, so a main commit that wrongly moved the selector would show;
- a pre-divisor of 2 combined with a main divisor of 3, which checks that the two stages multiply;
- an undefined selector code, which must stop the output.

Commit polling is sampled cycle by cycle to pin down the two-cycle clear.

// File: rtl/clkdiv_sel.sv
module clkdiv_sel #(
  parameter int N_PAR     = 4,
  parameter int SEL_W     = 3,
  parameter int SEL_SHIFT = 0,
  parameter int PRE_W     = 4,
  parameter int PRE_SHIFT = 8,
  parameter int DIV_W     = 8,
  parameter int DIV_SHIFT = 4,
  parameter int FRAC_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_en,
  input  logic [N_PAR-1:0] par_en,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  output logic             trig_busy,
  output logic             pretrig_busy,
  output logic             tick_o,
  output logic             sel_err
);
  localparam int AW = DIV_W + 2;
  localparam logic [AW-1:0] ONE = AW'(1) << FRAC_W;

  logic [DIV_W-1:0] div_sh, div_act;
  logic [SEL_W-1:0] sel_sh, sel_act;
  logic [PRE_W-1:0] pre_sh, pre_act, pcnt;
  logic [AW-1:0]    acc, dscale, nxt;
  logic             pend_div, pend_pre;
  logic [1:0]       cd_div, cd_pre;
  logic             p_raw, p, sel_ok, pre_tick, fire;
  logic             commit_div, commit_pre, wr_trig;

  always_comb begin
    p_raw = 1'b0;
    for (int i = 0; i < N_PAR; i++)
      if (sel_act == SEL_W'(i)) p_raw = par_en[i];
  end

  assign sel_ok   = 32'(sel_act) < N_PAR;
  assign p        = gate_en & sel_ok & p_raw;
  assign pre_tick = p & (pcnt == pre_act);
  assign dscale   = AW'(div_act) + ONE;
  assign nxt      = acc + ONE;
  assign fire     = pre_tick & (nxt >= dscale);

  assign wr_trig    = cfg_we & (cfg_addr == 2'd2) & gate_en;
  assign commit_div = pend_div & gate_en & (fire | ~sel_ok);
  assign commit_pre = pend_pre & gate_en & (pre_tick | ~sel_ok);

  assign trig_busy    = pend_div | (cd_div != 2'd0);
  assign pretrig_busy = pend_pre | (cd_pre != 2'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_sh <= '0;
      sel_sh <= '0;
      pre_sh <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == 2'd0) div_sh <= cfg_wdata[DIV_SHIFT +: DIV_W];
      if (cfg_addr == 2'd1) begin
        sel_sh <= cfg_wdata[SEL_SHIFT +: SEL_W];
        pre_sh <= cfg_wdata[PRE_SHIFT +: PRE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_div <= 1'b0;
      cd_div   <= 2'd0;
    end else if (commit_div) begin
      pend_div <= 1'b0;
      cd_div   <= 2'd2;
    end else begin
      if (wr_trig && cfg_wdata[0]) pend_div <= 1'b1;
      if (cd_div != 2'd0) cd_div <= cd_div - 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_pre <= 1'b0;
      cd_pre   <= 2'd0;
    end else if (commit_pre) begin
      pend_pre <= 1'b0;
      cd_pre   <= 2'd2;
    end else begin
      if (wr_trig && cfg_wdata[1]) pend_pre <= 1'b1;
      if (cd_pre != 2'd0) cd_pre <= cd_pre - 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_act <= '0;
      pre_act <= '0;
      pcnt    <= '0;
      sel_err <= 1'b0;
    end else if (commit_pre) begin
      sel_act <= sel_sh;
      pre_act <= pre_sh;
      pcnt    <= '0;
      if (32'(sel_sh) >= N_PAR) sel_err <= 1'b1;
    end else if (p) begin
      pcnt <= pre_tick ? '0 : pcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_act <= '0;
      acc     <= '0;
      tick_o  <= 1'b0;
    end else begin
      tick_o <= fire;
      if (commit_div) begin
        div_act <= div_sh;
        acc     <= '0;
      end else if (pre_tick) begin
        acc <= fire ? nxt - dscale : nxt;
      end
    end
  end
endmodule

module clkdiv_sel_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          gate_en,
  input logic          cfg_we,
  input logic [1:0]    cfg_addr,
  input logic [31:0]   cfg_wdata,
  input logic          trig_busy,
  input logic          pretrig_busy,
  input logic          tick_o,
  input logic          sel_err,
  input logic          sel_ok,
  input logic [AW-1:0] acc,
  input logic [AW-1:0] dscale
);
  a_r7_gate_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en |=> !tick_o);

  a_r7_trig_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 2'd2 && cfg_wdata[0] && !gate_en && !trig_busy) |=> !trig_busy);

  a_r6_busy_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 2'd2 && cfg_wdata[0] && gate_en) |=> trig_busy);

  a_r6_min_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trig_busy) |-> $past(trig_busy, 2));

  a_r6_min_prebusy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pretrig_busy) |-> $past(pretrig_busy, 2));

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    sel_err |=> sel_err);

  a_r9_no_pulse_undef: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_ok |=> !tick_o);

  a_r3_acc_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    acc < dscale);
endmodule

bind clkdiv_sel clkdiv_sel_chk #(.AW(AW)) u_chk (.*);

// File: tb/clkdiv_sel_tb.sv
`timescale 1ns/1ps
module clkdiv_sel_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gate_en = 1'b0;
  logic [3:0]  par_en = 4'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic        trig_busy, pretrig_busy, tick_o, sel_err;
  int          n_chk = 0, n_fail = 0, cyc = 0;

  always #2.5 clk = ~clk;

  clkdiv_sel u_dut (
    .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .par_en(par_en),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .trig_busy(trig_busy), .pretrig_busy(pretrig_busy),
    .tick_o(tick_o), .sel_err(sel_err)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    par_en <= {1'b0, (cyc % 3) == 0, cyc[0], 1'b1};
    if (cyc > 50000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles, expected < 50000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && (trig_busy || pretrig_busy); i++) @(negedge clk);
  endtask

  task automatic count(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tick_o) c++;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 tick_o", tick_o, 0);
    check("R1 trig_busy", trig_busy, 0);
    check("R1 pretrig_busy", pretrig_busy, 0);
    check("R1 sel_err", sel_err, 0);
    rst_n = 1'b1;
    gate_en = 1'b1;
  endtask

  task automatic t_default();
    int c;
    repeat (3) @(negedge clk);
    count(20, c);
    check("R1 R2 divide-by-1 pulses in 20", c, 20);
  endtask

  task automatic t_shadow();
    int c;
    wr(2'd0, 32'd8 << 4);
    wr(2'd1, 32'd1);
    count(20, c);
    check("R4 shadow only, pulses in 20", c, 20);
  endtask

  task automatic t_commit_timing();
    int c;
    wr(2'd2, 32'd1);
    check("R6 busy cycle 1", trig_busy, 1);
    @(negedge clk);
    check("R6 busy cycle 2", trig_busy, 1);
    @(negedge clk);
    check("R6 busy cycle 3", trig_busy, 1);
    @(negedge clk);
    check("R6 busy cleared", trig_busy, 0);
    check("R5 pre-commit untouched", pretrig_busy, 0);
    count(30, c);
    check("R2 R5 divide-by-3 on parent 0, pulses in 30", c, 10);
  endtask

  task automatic t_frac();
    int c, last, bad;
    wr(2'd0, 32'd6 << 4);
    wr(2'd2, 32'd1);
    wait_idle();
    c = 0; last = -1; bad = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (tick_o) begin
        c++;
        if (last >= 0 && (i - last) != 2 && (i - last) != 3) bad++;
        last = i;
      end
    end
    check("R3 divide-by-2.5 pulses in 100", c, 40);
    check("R3 intervals outside 2..3", bad, 0);
  endtask

  task automatic t_gate();
    int c;
    gate_en = 1'b0;
    @(negedge clk);
    count(10, c);
    check("R7 pulses while gated", c, 0);
    wr(2'd0, 32'd0);
    wr(2'd2, 32'd1);
    check("R7 busy after gated commit", trig_busy, 0);
    gate_en = 1'b1;
    repeat (2) @(negedge clk);
    check("R7 busy after reopen", trig_busy, 0);
    count(100, c);
    check("R7 divisor kept 2.5, pulses in 100", c, 40);
  endtask

  task automatic t_sel();
    int c;
    wr(2'd1, 32'd1);
    wr(2'd2, 32'd3);
    wait_idle();
    count(40, c);
    check("R8 parent 1 divide-by-1, pulses in 40", c, 20);
    wr(2'd1, 32'd1 << 8);
    wr(2'd0, 32'd8 << 4);
    wr(2'd2, 32'd3);
    wait_idle();
    count(60, c);
    check("R8 pre 2 x main 3, pulses in 60", c, 10);
  endtask

  task automatic t_undef();
    int c;
    wr(2'd1, 32'd5);
    wr(2'd2, 32'd2);
    wait_idle();
    check("R9 sel_err set", sel_err, 1);
    count(20, c);
    check("R9 pulses on undefined code", c, 0);
    wr(2'd1, 32'd0);
    wr(2'd2, 32'd2);
    wait_idle();
    check("R9 sel_err sticky", sel_err, 1);
    count(60, c);
    check("R9 R8 recovery divide-by-3, pulses in 60", c, 20);
  endtask

  initial begin
    t_reset();
    t_default();
    t_shadow();
    t_commit_timing();
    t_frac();
    t_gate();
    t_sel();
    t_undef();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule